// File: doc/BRIEF.md
# Spread Spectrum Frequency Profile Generator

This block drives a digital clock synthesizer with a frequency control word that sweeps slowly around a nominal value. Moving the instantaneous frequency spreads the energy a clock would otherwise concentrate at one frequency. Software or a static strap supplies five settings: a nominal word, a spread amount, a mode, a step period and an enable. The block works out the lower and upper sweep limits for the selected mode. It then walks the output word between those limits in a triangle, moving one least significant bit per step.

There are three modes, and each places the sweep envelope differently. Down spread keeps the nominal word as the ceiling. Up spread keeps it as the floor. Center spread swings by the same amount on both sides. A built-in phase accumulator adds the instantaneous word on every clock cycle, and its top bit is the synthesized output clock. When the enable is low the word rests at the nominal value, so the synthesizer's own jitter can be observed without modulation.

Top module: `ssfg_top`

## Requirements
- R1: Down mode (`mode_sel` = 0): the upper sweep limit equals `nominal_word` and the lower limit is `nominal_word` minus the excursion.
- R2: Center mode (`mode_sel` = 1 or 3): the limits are `nominal_word` plus and minus the excursion, so the peak-to-peak swing is twice the per-side amount.
- R3: Up mode (`mode_sel` = 2): the lower limit equals `nominal_word` and the upper limit is `nominal_word` plus the excursion.
- R4: The excursion is (`nominal_word` × `spread_amt`) >> EXC_SHIFT, truncated. The spread in percent per side is therefore 100 × `spread_amt` / 2^EXC_SHIFT.
- R5: The upper limit saturates at the all-ones word and the lower limit saturates at zero, so the frequency word never wraps.
- R6: While enabled, `freq_word` changes by exactly one per step, and a step occurs every `step_period`+1 clock cycles. At each limit the word turns around, spending one step holding at that limit.
- R7: After the enable rises, the walk starts at `nominal_word` and heads upward. In down mode it turns at once and heads down.
- R8: New values of mode, spread amount and step period take effect only at a turnaround. Until then the walk continues to the limit it was heading for.
- R9: While `spread_en` is low, `freq_word` equals the `nominal_word` present one clock earlier.
- R10: `clk_out` is the top bit of an ACC_W-bit phase accumulator that adds `freq_word` every cycle. Reset clears `freq_word` and `clk_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en | input | 1 | Enables the sweep; low holds the nominal word |
| nominal_word | input | FW_W | Unmodulated frequency word |
| spread_amt | input | SPR_W | Excursion per side in units of 2^-EXC_SHIFT of nominal |
| mode_sel | input | 2 | 0 down, 1 center, 2 up, 3 center |
| step_period | input | PER_W | Clock cycles per step, minus one |
| freq_word | output | FW_W | Instantaneous frequency word |
| clk_out | output | 1 | Phase accumulator top bit |

## Verification
The bench uses FW_W = 16 and ACC_W = 16. With these widths, a nominal word near 65535 needs only a few dozen steps to hit the upper saturation. A word of 4096 makes `clk_out` toggle with an exact 16-cycle period that can be counted. SPR_W = 12 combined with EXC_SHIFT = 10 allows the excursion to exceed the nominal word, which makes the zero floor reachable in down mode. The step period is set to 0, 1 and 3, so the bench covers stepping every cycle as well as slower stepping with measured spacing between steps.

// File: rtl/ssfg_pkg.sv
package ssfg_pkg;

  typedef enum logic [1:0] {
    SWEEP_BELOW  = 2'd0,
    SWEEP_AROUND = 2'd1,
    SWEEP_ABOVE  = 2'd2,
    SWEEP_ALT    = 2'd3
  } sweep_mode_e;

  function automatic sweep_mode_e norm_mode(input logic [1:0] code);
    sweep_mode_e m;
    m = sweep_mode_e'(code);
    if (m == SWEEP_ALT) m = SWEEP_AROUND;
    return m;
  endfunction

endpackage

// File: rtl/ssfg_limits.sv
module ssfg_limits
  import ssfg_pkg::*;
#(
  parameter int FW_W      = 16,
  parameter int SPR_W     = 12,
  parameter int EXC_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FW_W-1:0]  nom_i,
  input  logic [SPR_W-1:0] spr_i,
  input  logic [1:0]       mode_i,
  output logic [FW_W-1:0]  lo_o,
  output logic [FW_W-1:0]  hi_o
);

  localparam int PW = FW_W + SPR_W;

  logic [PW-1:0]   prod;
  logic [PW-1:0]   exc;
  logic [PW:0]     up_sum;
  logic [FW_W-1:0] top_word;
  logic [FW_W-1:0] floor_word;
  logic [FW_W-1:0] lo_next;
  logic [FW_W-1:0] hi_next;
  sweep_mode_e     mode;

  always_comb begin
    prod   = PW'(nom_i) * PW'(spr_i);
    exc    = prod >> EXC_SHIFT;
    up_sum = (PW+1)'(nom_i) + (PW+1)'(exc);
    if (up_sum > (PW+1)'({FW_W{1'b1}}))
      top_word = {FW_W{1'b1}};
    else
      top_word = up_sum[FW_W-1:0];
    if (exc > PW'(nom_i))
      floor_word = '0;
    else
      floor_word = nom_i - exc[FW_W-1:0];
  end

  always_comb begin
    mode = norm_mode(mode_i);
    case (mode)
      SWEEP_BELOW: begin
        lo_next = floor_word;
        hi_next = nom_i;
      end
      SWEEP_ABOVE: begin
        lo_next = nom_i;
        hi_next = top_word;
      end
      default: begin
        lo_next = floor_word;
        hi_next = top_word;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o <= '0;
      hi_o <= '0;
    end else begin
      lo_o <= lo_next;
      hi_o <= hi_next;
    end
  end

  // R1
  down_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> (hi_o == $past(nom_i)));

  // R3
  up_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2) |=> (lo_o == $past(nom_i)));

  // R2
  center_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 || mode_i == 2'd3) |=>
      (hi_o == {FW_W{1'b1}} || lo_o == '0 ||
       (hi_o - $past(nom_i)) == ($past(nom_i) - lo_o)));

endmodule

// File: rtl/ssfg_ratediv.sv
module ssfg_ratediv #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PER_W-1:0] per_i,
  output logic             tick_o
);

  logic [PER_W-1:0] cnt;

  assign tick_o = run_i && (cnt == per_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (tick_o)   cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && per_i != '0) |=> !tick_o);

endmodule

// File: rtl/ssfg_walker.sv
module ssfg_walker #(
  parameter int FW_W  = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [FW_W-1:0]  nom_i,
  input  logic [FW_W-1:0]  lo_i,
  input  logic [FW_W-1:0]  hi_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [PER_W-1:0] per_o,
  output logic [FW_W-1:0]  word_o
);

  logic            rising;
  logic [FW_W-1:0] lo_l;
  logic [FW_W-1:0] hi_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      rising <= 1'b1;
      lo_l   <= '0;
      hi_l   <= '0;
      per_o  <= '0;
      run_o  <= 1'b0;
    end else if (!en_i) begin
      word_o <= nom_i;
      rising <= 1'b1;
      lo_l   <= lo_i;
      hi_l   <= hi_i;
      per_o  <= per_i;
      run_o  <= 1'b0;
    end else begin
      run_o <= 1'b1;
      if (tick_i) begin
        if (rising) begin
          if (word_o >= hi_l) begin
            rising <= 1'b0;
            lo_l   <= lo_i;
            hi_l   <= hi_i;
            per_o  <= per_i;
          end else begin
            word_o <= word_o + 1'b1;
          end
        end else begin
          if (word_o <= lo_l) begin
            rising <= 1'b1;
            lo_l   <= lo_i;
            hi_l   <= hi_i;
            per_o  <= per_i;
          end else begin
            word_o <= word_o - 1'b1;
          end
        end
      end
    end
  end

  // R9
  idle_nominal_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (word_o == $past(nom_i)));

  // R6
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (word_o == $past(word_o) || word_o == $past(word_o) + 1'b1 ||
              $past(word_o) == word_o + 1'b1));

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !tick_i) |=> (word_o == $past(word_o)));

endmodule

// File: rtl/ssfg_phase.sv
module ssfg_phase #(
  parameter int FW_W  = 16,
  parameter int ACC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FW_W-1:0] word_i,
  output logic            clk_o
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc;

  generate
    if (ACC_W == FW_W) begin : g_same
      assign inc = word_i;
    end else begin : g_wide
      assign inc = {{(ACC_W-FW_W){1'b0}}, word_i};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + inc;
  end

  assign clk_o = acc[ACC_W-1];

  // R10
  zero_word_still_chk: assert property (@(posedge clk) disable iff (rst)
    (word_i == '0) |=> $stable(clk_o));

endmodule

// File: rtl/ssfg_top.sv
module ssfg_top #(
  parameter int FW_W      = 16,
  parameter int SPR_W     = 12,
  parameter int EXC_SHIFT = 10,
  parameter int PER_W     = 16,
  parameter int ACC_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spread_en,
  input  logic [FW_W-1:0]  nominal_word,
  input  logic [SPR_W-1:0] spread_amt,
  input  logic [1:0]       mode_sel,
  input  logic [PER_W-1:0] step_period,
  output logic [FW_W-1:0]  freq_word,
  output logic             clk_out
);

  logic [FW_W-1:0]  lim_lo;
  logic [FW_W-1:0]  lim_hi;
  logic             run;
  logic             tick;
  logic [PER_W-1:0] per_live;

  ssfg_limits #(.FW_W(FW_W), .SPR_W(SPR_W), .EXC_SHIFT(EXC_SHIFT)) u_limits (
    .clk(clk), .rst(rst), .nom_i(nominal_word), .spr_i(spread_amt),
    .mode_i(mode_sel), .lo_o(lim_lo), .hi_o(lim_hi)
  );

  ssfg_ratediv #(.PER_W(PER_W)) u_div (
    .clk(clk), .rst(rst), .run_i(run), .per_i(per_live), .tick_o(tick)
  );

  ssfg_walker #(.FW_W(FW_W), .PER_W(PER_W)) u_walk (
    .clk(clk), .rst(rst), .en_i(spread_en), .nom_i(nominal_word),
    .lo_i(lim_lo), .hi_i(lim_hi), .per_i(step_period), .tick_i(tick),
    .run_o(run), .per_o(per_live), .word_o(freq_word)
  );

  ssfg_phase #(.FW_W(FW_W), .ACC_W(ACC_W)) u_phase (
    .clk(clk), .rst(rst), .word_i(freq_word), .clk_o(clk_out)
  );

endmodule

// File: tb/test_ssfg_top.sv
module test_ssfg_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spread_en = 1'b0;
  logic [15:0] nominal_word = '0;
  logic [11:0] spread_amt = '0;
  logic [1:0]  mode_sel = '0;
  logic [15:0] step_period = '0;
  logic [15:0] freq_word;
  logic        clk_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];
  int exp_tag[$];
  bit sb_on = 1'b0;
  int sb_last = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ssfg_top i_ssfg_top (
    .clk(clk), .rst(rst), .spread_en(spread_en), .nominal_word(nominal_word),
    .spread_amt(spread_amt), .mode_sel(mode_sel), .step_period(step_period),
    .freq_word(freq_word), .clk_out(clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int excursion(input int nom, input int spr);
    return (nom * spr) >> 10; // R4
  endfunction

  task automatic push_ramp(input int from, input int to, input int tag);
    if (from < to) for (int v = from + 1; v <= to; v++) begin exp_q.push_back(v); exp_tag.push_back(tag); end
    else           for (int v = from - 1; v >= to; v--) begin exp_q.push_back(v); exp_tag.push_back(tag); end
  endtask

  task automatic setup(input int nom, input int spr, input int mode, input int per);
    @(negedge clk);
    spread_en    = 1'b0;
    nominal_word = 16'(nom);
    spread_amt   = 12'(spr);
    mode_sel     = 2'(mode);
    step_period  = 16'(per);
    repeat (4) @(negedge clk);
  endtask

  task automatic drain_and_stop(input int nom);
    while (exp_q.size() != 0) @(negedge clk);
    sb_on = 1'b0;
    spread_en = 1'b0;
    @(negedge clk);
    check("R9", int'(freq_word), nom);
  endtask

  // monitor: pops expected values as the word changes
  always @(negedge clk) begin
    if (!sb_on) sb_last = int'(freq_word);
    else if (int'(freq_word) != sb_last) begin
      if (exp_q.size() != 0) begin
        int e, t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        case (t)
          1: check("R1", int'(freq_word), e);
          2: check("R2", int'(freq_word), e);
          3: check("R3", int'(freq_word), e);
          5: check("R5", int'(freq_word), e);
          default: check("R8", int'(freq_word), e);
        endcase
      end
      sb_last = int'(freq_word);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e, rises, c1, c2, v;
    bit prev;
    repeat (3) @(negedge clk);
    // R10 reset values
    check("R10", int'(freq_word), 0);
    check("R10", int'(clk_out), 0);
    rst = 1'b0;

    // R9 disabled holds nominal; R10 clock period 65536/4096 = 16 cycles
    setup(4096, 10, 0, 1);
    check("R9", int'(freq_word), 4096);
    rises = 0;
    prev = clk_out;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
    check("R10", rises, 16);

    // R1 R7 down: 4096 down to 4056 and back
    e = excursion(4096, 10);
    check("R4", e, 40);
    push_ramp(4096, 4096 - e, 1);
    push_ramp(4096 - e, 4096, 1);
    sb_on = 1'b1;
    spread_en = 1'b1;
    drain_and_stop(4096);

    // R2 center, code 1
    setup(4096, 10, 1, 1);
    push_ramp(4096, 4096 + e, 2);
    push_ramp(4096 + e, 4096 - e, 2);
    push_ramp(4096 - e, 4096, 2);
    sb_on = 1'b1;
    spread_en = 1'b1;
    drain_and_stop(4096);

    // R3 up with period 3; R6 step spacing of 4 cycles
    setup(4096, 10, 2, 3);
    push_ramp(4096, 4096 + e, 3);
    push_ramp(4096 + e, 4096, 3);
    sb_on = 1'b1;
    spread_en = 1'b1;
    v = int'(freq_word);
    while (int'(freq_word) == v) @(negedge clk);
    c1 = cyc; v = int'(freq_word);
    while (int'(freq_word) == v) @(negedge clk);
    c2 = cyc;
    check("R6", c2 - c1, 4);
    drain_and_stop(4096);

    // R5 ceiling saturation
    setup(65500, 10, 2, 1);
    push_ramp(65500, 65535, 5);
    push_ramp(65535, 65500, 5);
    sb_on = 1'b1;
    spread_en = 1'b1;
    drain_and_stop(65500);

    // R5 floor saturation: excursion 40 exceeds nominal 20
    setup(20, 2048, 0, 1);
    push_ramp(20, 0, 5);
    push_ramp(0, 20, 5);
    sb_on = 1'b1;
    spread_en = 1'b1;
    drain_and_stop(20);

    // R8 mode change mid-descent waits for bottom turnaround; code 3 is center
    setup(4096, 10, 3, 0);
    push_ramp(4096, 4136, 8);
    push_ramp(4136, 4056, 8);
    push_ramp(4056, 4136, 8);
    push_ramp(4136, 4096, 8);
    sb_on = 1'b1;
    spread_en = 1'b1;
    while (int'(freq_word) != 4136) @(negedge clk);
    while (int'(freq_word) != 4130) @(negedge clk);
    mode_sel = 2'd2;
    drain_and_stop(4096);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule